// File: doc/BRIEF.md
# Data-Valid Serial Frame Transmitter

This block watches an asynchronous, active-low data-valid input. Each time that input falls, it sends one 40-bit frame on a two-wire serial link. The link is a clock line and a data line, both toggling at one tenth of the system clock, so 5 MHz from a 50 MHz system clock. Each frame starts with a fixed 8-bit header. The remaining 32 bits are the frame sequence number present on `seq_num` when the frame starts, so a receiver can line up its data with the counter used elsewhere in the system.

Address-return-to-zero events have their own strobe input, and the block ignores that strobe completely. Only data-valid edges start frames. If a data-valid edge arrives while a frame is still shifting out, the block remembers it in one pending flag and starts the next frame directly after the current one ends. The serial interface is a free-running broadcast with no back-pressure, so it has no valid/ready handshake. Every pin is a plain control or data line.

Top module: `dvfx_tx`

## Requirements
- R1: While reset is asserted and in the cycles right after it, `ser_clk` and `ser_data` are both 0.
- R2: A high-to-low transition of `dv_in` that has passed the two-flop synchronizer starts a frame. A low-to-high transition starts nothing.
- R3: A frame is 40 bits, sent most significant bit first. Bits 39..32 are the header 0xA5. Bits 31..0 are `seq_num` as sampled in the cycle the frame is loaded, so later changes of `seq_num` do not alter a frame already in progress.
- R4: During a frame, `ser_clk` has a period of 10 system clocks. It is high for 5 and low for 5. A frame has exactly 40 rising edges of `ser_clk`.
- R5: `ser_data` changes only while `ser_clk` is low. It is stable through every high phase of `ser_clk`, and a receiver samples it on the rising edge.
- R6: A falling edge of `dv_in` seen during a frame is held as pending. The next frame follows with no idle gap: its first rising `ser_clk` edge comes exactly 10 system clocks after the last rising edge of the previous frame.
- R7: Any number of falling edges during one frame together produce exactly one extra frame. The pending flag is only ever set while a frame is in progress.
- R8: `arz_evt` has no effect. It starts no frame and changes no frame content.
- R9: When no frame is in progress, `ser_clk` and `ser_data` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (nominally 50 MHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| dv_in | input | 1 | Asynchronous data-valid line; its falling edges start frames |
| seq_num | input | 32 | Current frame sequence number, loaded at frame start |
| arz_evt | input | 1 | Address-return-to-zero strobe; ignored |
| ser_clk | output | 1 | Serial clock, system clock divided by 10 while a frame is sent |
| ser_data | output | 1 | Serial data, MSB first, valid at rising `ser_clk` |

## Verification
The assertions assume that `dv_in` holds each level for at least three system clocks. Shorter pulses may be lost in the synchronizer, and the edge-to-start property would then not apply. The stimulus holds every `dv_in` level for four or more cycles and never changes it more often than that. `seq_num` is changed at random times, including during frames, because the requirement fixes its sample point at frame load. `arz_evt` is pulsed at random on any cycle, including while a frame is shifting.

// File: rtl/dvfx_pkg.sv
package dvfx_pkg;
  // Build the parallel word that is shifted out: header above sequence number.
  function automatic logic [39:0] build_word(input logic [7:0] hdr, input logic [31:0] seq);
    return {hdr, seq};
  endfunction
endpackage

// File: rtl/dvfx_sync_edge.sv
module dvfx_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic fall_pulse
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  // Synchronizer chain, reset to the idle (high) level.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_in};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign fall_pulse = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/dvfx_bit_timer.sv
module dvfx_bit_timer #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic bit_end
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] HALF_V = PW'(DIV / 2);
  localparam logic [PW-1:0] LAST_V = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      phase_q <= '0;
    end else if (phase_q == LAST_V) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  // Low for the first half of each bit slot, high for the second.
  assign sclk    = run && (phase_q >= HALF_V);
  assign bit_end = run && (phase_q == LAST_V);
endmodule

// File: rtl/dvfx_framer.sv
module dvfx_framer
  import dvfx_pkg::*;
#(
  parameter int           SEQ_W  = 32,
  parameter int           HDR_W  = 8,
  parameter logic [7:0]   HEADER = 8'hA5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_evt,
  input  logic             bit_end,
  input  logic [SEQ_W-1:0] seq_num,
  output logic             busy,
  output logic             pend,
  output logic             sdata
);
  localparam int FW = SEQ_W + HDR_W;
  localparam int CW = $clog2(FW);
  localparam logic [CW-1:0] LAST_BIT = CW'(FW - 1);

  logic [FW-1:0] shreg_q;
  logic [CW-1:0] bitcnt_q;
  logic          busy_q;
  logic          pend_q;
  logic [FW-1:0] load_word;

  assign load_word = build_word(HEADER, seq_num);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg_q  <= '0;
      bitcnt_q <= '0;
      busy_q   <= 1'b0;
      pend_q   <= 1'b0;
    end else if (!busy_q) begin
      if (start_evt) begin
        busy_q   <= 1'b1;
        shreg_q  <= load_word;
        bitcnt_q <= '0;
      end
    end else begin
      if (start_evt) pend_q <= 1'b1;
      if (bit_end) begin
        if (bitcnt_q == LAST_BIT) begin
          if (pend_q || start_evt) begin
            shreg_q  <= load_word;
            bitcnt_q <= '0;
            pend_q   <= 1'b0;
          end else begin
            busy_q   <= 1'b0;
            shreg_q  <= '0;
          end
        end else begin
          shreg_q  <= shreg_q << 1;
          bitcnt_q <= bitcnt_q + 1'b1;
        end
      end
    end
  end

  assign busy  = busy_q;
  assign pend  = pend_q;
  assign sdata = busy_q & shreg_q[FW-1];
endmodule

// File: rtl/dvfx_tx.sv
module dvfx_tx #(
  parameter int         DIV     = 10,
  parameter int         SYNC_N  = 2,
  parameter int         SEQ_W   = 32,
  parameter int         HDR_W   = 8,
  parameter logic [7:0] HEADER  = 8'hA5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dv_in,
  input  logic [SEQ_W-1:0] seq_num,
  input  logic             arz_evt,
  output logic             ser_clk,
  output logic             ser_data
);
  logic dv_fall;
  logic busy;
  logic pend_flag;
  logic bit_end;
  logic arz_unused;

  // Return-to-zero events are deliberately kept out of the stream.
  assign arz_unused = arz_evt;

  dvfx_sync_edge #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(dv_in), .fall_pulse(dv_fall)
  );

  dvfx_bit_timer #(.DIV(DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .sclk(ser_clk), .bit_end(bit_end)
  );

  dvfx_framer #(.SEQ_W(SEQ_W), .HDR_W(HDR_W), .HEADER(HEADER)) u_framer (
    .clk(clk), .rst_n(rst_n), .start_evt(dv_fall), .bit_end(bit_end),
    .seq_num(seq_num), .busy(busy), .pend(pend_flag), .sdata(ser_data)
  );
endmodule

// File: rtl/dvfx_tx_chk.sv
module dvfx_tx_chk #(
  parameter int DIV = 10
) (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic sdata,
  input logic busy,
  input logic dv_fall,
  input logic pend
);
  localparam int HALF = DIV / 2;
  int unsigned hi_len;

  always_ff @(posedge clk) begin
    if (!rst_n)    hi_len <= 0;
    else if (sclk) hi_len <= hi_len + 1;
    else           hi_len <= 0;
  end

  // R9
  idle_lines_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && !sdata));

  // R5
  data_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdata));

  // R4
  clk_high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk && $past(sclk)) |-> (hi_len == HALF));

  // R2
  edge_starts_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && dv_fall) |=> busy);

  // R7
  pend_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> busy);
endmodule

bind dvfx_tx dvfx_tx_chk #(.DIV(DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(ser_clk), .sdata(ser_data),
  .busy(busy), .dv_fall(dv_fall), .pend(pend_flag)
);

// File: tb/tb_dvfx_tx.sv
`timescale 1ns/1ps
module tb_dvfx_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dv_in = 1'b1;
  logic [31:0] seq_num = '0;
  logic        arz_evt = 1'b0;
  logic        ser_clk, ser_data;

  int tests = 0, fails = 0, cyc = 0;

  dvfx_tx dut (.clk(clk), .rst_n(rst_n), .dv_in(dv_in), .seq_num(seq_num),
               .arz_evt(arz_evt), .ser_clk(ser_clk), .ser_data(ser_data));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [39:0] exp_frame(input logic [31:0] s);
    return {8'hA5, s};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Receiver model: samples data on each rising serial clock.
  logic [39:0] frames [64];
  int first_r [64];
  int last_r  [64];
  int nf = 0, nb = 0, per_err = 0, stab_err = 0, last_rise = 0, cur_first = 0;
  logic [39:0] bits = '0;
  logic prev_sclk = 1'b0, held = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      nb = 0; prev_sclk = 1'b0;
    end else begin
      if (ser_clk && !prev_sclk) begin
        bits = {bits[38:0], ser_data};
        held = ser_data;
        if (nb == 0) cur_first = cyc;
        else if (cyc - last_rise != 10) per_err++;
        last_rise = cyc;
        nb++;
        if (nb == 40) begin
          if (nf < 64) begin
            frames[nf] = bits; first_r[nf] = cur_first; last_r[nf] = cyc;
          end
          nf++;
          nb = 0;
        end
      end else if (ser_clk && prev_sclk && ser_data != held) begin
        stab_err++;
      end
      prev_sclk = ser_clk;
    end
  end

  task automatic wait_cyc(input int n, input bit arz_rand);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      arz_evt = arz_rand ? (($urandom % 6) == 0) : 1'b0;
    end
    arz_evt = 1'b0;
  endtask

  initial begin : watchdog
    #600000;
    fails++; tests++;
    $display("FAIL watchdog expired actual=%0d expected<150000 cycles", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int base;
    logic [31:0] s_a, s_b;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    // R1: reset state
    check(ser_clk == 1'b0 && ser_data == 1'b0, "R1 reset lines", {ser_clk, ser_data}, 0);
    rst_n = 1'b1;
    wait_cyc(3, 0);
    check(ser_clk == 1'b0 && ser_data == 1'b0, "R1 after reset", {ser_clk, ser_data}, 0);

    // R2/R3/R4: single directed frame
    seq_num = 32'h1234_5678;
    base = nf;
    dv_in = 1'b0;
    wait_cyc(480, 0);
    check(nf == base + 1, "R2 one frame per fall", nf - base, 1);
    check(frames[base] == exp_frame(32'h1234_5678), "R3 frame content", frames[base], exp_frame(32'h1234_5678));
    check(per_err == 0, "R4 serial clock period", per_err, 0);
    check(nb == 0, "R4 exactly 40 edges", nb, 0);
    check(ser_clk == 1'b0 && ser_data == 1'b0, "R9 idle after frame", {ser_clk, ser_data}, 0);

    // R2: rising edge starts nothing
    base = nf;
    dv_in = 1'b1;
    wait_cyc(480, 0);
    check(nf == base && nb == 0, "R2 rising edge ignored", nf - base, 0);

    // R8: return-to-zero strobes while idle
    wait_cyc(300, 1);
    wait_cyc(20, 0);
    check(nf == base && nb == 0 && ser_clk == 1'b0, "R8 strobe no frame", nf - base, 0);

    // R6/R7/R3: edges during a frame, seq changed mid-frame
    s_a = 32'hCAFE_0001; s_b = 32'h0BAD_F00D;
    seq_num = s_a;
    base = nf;
    dv_in = 1'b0;
    wait_cyc(50, 0);  seq_num = s_b;
    wait_cyc(50, 0);  dv_in = 1'b1;
    wait_cyc(10, 0);  dv_in = 1'b0;
    wait_cyc(40, 0);  dv_in = 1'b1;
    wait_cyc(10, 0);  dv_in = 1'b0;
    wait_cyc(1000, 0);
    check(nf == base + 2, "R7 collapse to one extra frame", nf - base, 2);
    check(frames[base] == exp_frame(s_a), "R3 seq sampled at load", frames[base], exp_frame(s_a));
    check(frames[base+1] == exp_frame(s_b), "R6 pending frame content", frames[base+1], exp_frame(s_b));
    check(first_r[base+1] - last_r[base] == 10, "R6 no gap between frames",
          first_r[base+1] - last_r[base], 10);
    dv_in = 1'b1;
    wait_cyc(10, 0);

    // Random frames with strobes (R2 R3 R8)
    for (int it = 0; it < 20; it++) begin
      logic [31:0] s;
      s = $urandom;
      seq_num = s;
      base = nf;
      wait_cyc(4 + ($urandom % 16), 1);
      dv_in = 1'b0;
      wait_cyc(4 + ($urandom % 26), 1);
      dv_in = 1'b1;
      wait_cyc(440, 1);
      check(nf == base + 1 && frames[base] == exp_frame(s), "R8 random frame with strobes",
            frames[base], exp_frame(s));
    end

    check(per_err == 0, "R4 period over all frames", per_err, 0);
    check(stab_err == 0, "R5 data stable while clock high", stab_err, 0);
    check(ser_clk == 1'b0 && ser_data == 1'b0, "R9 final idle", {ser_clk, ser_data}, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule